// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block is a clock-master serial audio transmitter. It divides the system clock to produce a bit clock and a frame clock. Once per frame it accepts one left/right PCM pair over a valid/ready handshake. It shifts that pair out MSB first on a single data line, in one of five framings: I2S, left-justified, right-justified, DSP_A or DSP_B (short-frame PCM).

All configuration inputs are static and are expected to change only while reset is held. The frame clock half-period is programmed in bit clocks minus one. The format picks the data offset and the default frame-clock start level: I2S starts a frame with the frame clock low, and every other format starts it high. A frame-invert input toggles that default start level. A separate bit-clock-invert input only flips the bit clock pin, so data still changes on the edge opposite the receiver's sampling edge. If no pair is offered when a frame begins, the frame carries zeros and an underrun flag is raised for that frame.

Top module: `aud_ser_tx`

## Requirements
- R1: The internal bit clock has a period of 2*CLK_DIV system clocks. bclk_o equals the internal clock XOR bclk_inv_i, and the internal clock sits high during reset. lrclk_o and sdata_o change only on the internal falling edge, so a receiver samples them on the internal rising edge.
- R2: A frame lasts 2*(half_period_i+1) bit clocks, and every frame begins with lrclk_o at the start level.
- R3: With fmt_i=0 (I2S) the default start level is 0. The left word is sent while lrclk_o is low and the right word while it is high, each MSB delayed one bit clock after the lrclk_o transition.
- R4: With fmt_i=1 (left-justified) the default start level is 1, and each word's MSB occupies the first bit clock of its half-frame.
- R5: With fmt_i=2 (right-justified) the default start level is 1. Each word's LSB occupies the last bit clock of its half-frame, and the leading slots carry zeros.
- R6: With fmt_i=3 (DSP_A), lrclk_o is at the start level (default 1) for exactly the first bit clock of the frame. The left MSB follows one bit clock later, the right word follows the left LSB directly, and the remaining slots are zero.
- R7: With fmt_i=4 (DSP_B) the framing is as in R6, but the left MSB shares the first bit clock with the frame pulse.
- R8: frame_inv_i=1 toggles the format's default start level and leaves the data placement unchanged.
- R9: bclk_inv_i=1 inverts bclk_o only; the data and frame clock keep their position relative to the sampling edge.
- R10: s_ready_o is high for exactly one system cycle at the start of each frame, and the pair accepted in that cycle is the one sent in that frame.
- R11: When s_valid_i is low while s_ready_o is high, the frame sends zero words and underrun_o is 1 for that whole frame. It returns to 0 for the next frame that receives a valid pair.
- R12: When half_period_i+1 equals SAMPLE_W and the offset is one bit clock, the right LSB of a frame is sent in the first slot of the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 3 | Format: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP_A, 4 DSP_B (5..7 act as I2S) |
| half_period_i | input | HALF_W | Frame clock half-period in bit clocks, minus one (must be at least SAMPLE_W-1) |
| frame_inv_i | input | 1 | Toggle the format's default frame start level |
| bclk_inv_i | input | 1 | Invert the bit clock pin |
| s_valid_i | input | 1 | Sample pair valid |
| s_ready_o | output | 1 | One-cycle pulse at frame start: the pair is taken |
| s_left_i | input | SAMPLE_W | Left sample |
| s_right_i | input | SAMPLE_W | Right sample |
| bclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Serial frame clock |
| sdata_o | output | 1 | Serial data, MSB first |
| underrun_o | output | 1 | Current frame was zero-filled for lack of a pair |

## Verification
The bench records every sampled bit and compares it with a stream rebuilt from the sample words. This catches a lost or extra offset slot, which would shift the whole stream by one position, and a swapped I2S start level, which would send left on high. The half-period-equals-width case checks that the right LSB spills into the next frame, so a design that dropped or zeroed it is caught. Running with the bit clock inverted shows whether data moves onto the sampling edge. The underrun case checks that a stale pair is not repeated and that the flag clears on the next valid pair.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  typedef enum logic [2:0] {
    FMT_I2S  = 3'd0,
    FMT_LJ   = 3'd1,
    FMT_RJ   = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmt_e;

  function automatic logic fmt_is_dsp(input logic [2:0] f);
    return (f == FMT_DSPA) || (f == FMT_DSPB);
  endfunction

  function automatic logic fmt_is_rj(input logic [2:0] f);
    return f == FMT_RJ;
  endfunction

  // one-BCLK data offset: I2S, DSP_A and unused codes (treated as I2S)
  function automatic logic fmt_offset(input logic [2:0] f);
    return !((f == FMT_LJ) || (f == FMT_RJ) || (f == FMT_DSPB));
  endfunction

  // level of lrclk during the first slot of a frame, before frame inversion
  function automatic logic fmt_start_lvl(input logic [2:0] f);
    return (f == FMT_LJ) || (f == FMT_RJ) || (f == FMT_DSPA) || (f == FMT_DSPB);
  endfunction

endpackage

// File: rtl/aud_ser_clkgen.sv
module aud_ser_clkgen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ph_o,
  output logic fall_o
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] cnt_q;
  logic          ph_q;
  logic          tick;

  assign tick = (cnt_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) ph_q <= ~ph_q;
    end
  end

  assign ph_o   = ph_q;
  assign fall_o = tick & ph_q;

  assert_fall_from_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !ph_o);

endmodule

// File: rtl/aud_ser_framer.sv
module aud_ser_framer
  import aud_ser_pkg::*;
#(
  parameter int HALF_W = 10,
  parameter int K_W    = HALF_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic [2:0]        fmt_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              finv_i,
  output logic              load_o,
  output logic [K_W-1:0]    slot_n_o,
  output logic [K_W-1:0]    slot_o,
  output logic              lrclk_o
);
  logic [K_W-1:0] slot_q, last, n;
  logic           run_q, lr_q, lr_n, start, wrap_pt;

  assign last    = {1'b0, half_i, 1'b1};
  assign n       = {2'b00, half_i} + 1'b1;
  assign start   = fmt_start_lvl(fmt_i) ^ finv_i;
  assign wrap_pt = !run_q || (slot_q == last);
  assign load_o  = fall_i && wrap_pt;

  always_comb begin
    slot_n_o = wrap_pt ? '0 : slot_q + 1'b1;
    if (fmt_is_dsp(fmt_i)) lr_n = (slot_n_o == '0) ? start : ~start;
    else                   lr_n = (slot_n_o < n)    ? start : ~start;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      run_q  <= 1'b0;
      lr_q   <= 1'b0;
    end else if (fall_i) begin
      slot_q <= slot_n_o;
      run_q  <= 1'b1;
      lr_q   <= lr_n;
    end
  end

  assign slot_o  = slot_q;
  assign lrclk_o = lr_q;

  assert_ready_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  assert_frame_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && run_q && slot_q == last) |=> (slot_q == '0 && lrclk_o == start));

  assert_dsp_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_is_dsp(fmt_i) && run_q && fall_i && lrclk_o == start) |=> (lrclk_o != start));

endmodule

// File: rtl/aud_ser_shifter.sv
module aud_ser_shifter
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int HALF_W   = 10,
  parameter int K_W      = HALF_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  logic                load_i,
  input  logic [K_W-1:0]      slot_n_i,
  input  logic [HALF_W-1:0]   half_i,
  input  logic [2:0]          fmt_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o,
  output logic                underrun_o
);
  localparam logic [K_W-1:0] W_K  = K_W'(SAMPLE_W);
  localparam logic [K_W-1:0] W2_K = K_W'(2 * SAMPLE_W);

  logic [SAMPLE_W-1:0] cur_l, cur_r, nl, nr, wr, word, sh;
  logic [K_W-1:0]      n, len, p, q, idx;
  logic                off, wrap, ch, hit, bit_n, sd_q, un_q;

  assign n   = {2'b00, half_i} + 1'b1;
  assign len = {1'b0, half_i, 1'b0} + K_W'(2);
  assign off = fmt_offset(fmt_i);

  always_comb begin
    wrap = off && (slot_n_i == '0);
    p    = wrap ? len - 1'b1 : slot_n_i - {{(K_W-1){1'b0}}, off};
    nl   = load_i ? (valid_i ? left_i  : '0) : cur_l;
    nr   = load_i ? (valid_i ? right_i : '0) : cur_r;
    // slot spilled over from the previous frame reads the still-held right word
    wr   = wrap ? cur_r : nr;
    word = '0;
    idx  = '0;
    hit  = 1'b0;
    ch   = 1'b0;
    q    = '0;
    if (fmt_is_dsp(fmt_i)) begin
      if (p < W_K) begin
        word = nl; idx = W_K - 1'b1 - p; hit = 1'b1;
      end else if (p < W2_K) begin
        word = wr; idx = W2_K - 1'b1 - p; hit = 1'b1;
      end
    end else begin
      ch   = (p >= n);
      q    = ch ? p - n : p;
      word = ch ? wr : nl;
      if (fmt_is_rj(fmt_i)) begin
        hit = (q + W_K >= n);
        idx = n - 1'b1 - q;
      end else begin
        hit = (q < W_K);
        idx = W_K - 1'b1 - q;
      end
    end
    sh    = word >> idx;
    bit_n = hit & sh[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_l <= '0;
      cur_r <= '0;
      sd_q  <= 1'b0;
      un_q  <= 1'b0;
    end else begin
      if (fall_i) sd_q <= bit_n;
      if (load_i) begin
        cur_l <= valid_i ? left_i  : '0;
        cur_r <= valid_i ? right_i : '0;
        un_q  <= !valid_i;
      end
    end
  end

  assign sdata_o    = sd_q;
  assign underrun_o = un_q;

  assert_underrun_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !valid_i) |=> underrun_o);

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CLK_DIV  = 2,
  parameter int HALF_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          fmt_i,
  input  logic [HALF_W-1:0]   half_period_i,
  input  logic                frame_inv_i,
  input  logic                bclk_inv_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [SAMPLE_W-1:0] s_left_i,
  input  logic [SAMPLE_W-1:0] s_right_i,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                sdata_o,
  output logic                underrun_o
);
  localparam int K_W = HALF_W + 2;

  logic           ph, fall, load;
  logic [K_W-1:0] slot_n, slot_q;

  aud_ser_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph_o(ph), .fall_o(fall)
  );

  aud_ser_framer #(.HALF_W(HALF_W), .K_W(K_W)) u_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall), .fmt_i(fmt_i),
    .half_i(half_period_i), .finv_i(frame_inv_i), .load_o(load),
    .slot_n_o(slot_n), .slot_o(slot_q), .lrclk_o(lrclk_o)
  );

  aud_ser_shifter #(.SAMPLE_W(SAMPLE_W), .HALF_W(HALF_W), .K_W(K_W)) u_shifter (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall), .load_i(load),
    .slot_n_i(slot_n), .half_i(half_period_i), .fmt_i(fmt_i),
    .valid_i(s_valid_i), .left_i(s_left_i), .right_i(s_right_i),
    .sdata_o(sdata_o), .underrun_o(underrun_o)
  );

  assign s_ready_o = load;
  assign bclk_o    = ph ^ bclk_inv_i;

  assert_launch_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> ($stable(sdata_o) && $stable(lrclk_o)));

  assert_underrun_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && slot_q != '0) |-> !sdata_o);

endmodule

// File: tb/aud_ser_tx_test.sv
module aud_ser_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int DIV = 2;
  localparam int HW  = 10;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [2:0]    fmt = 3'd0;
  logic [HW-1:0] hp  = 10'd19;
  logic          finv = 1'b0, binv = 1'b0;
  logic          s_valid = 1'b0;
  logic [W-1:0]  s_left = '0, s_right = '0;
  logic          s_ready, bclk, lrclk, sdata, underrun;

  aud_ser_tx #(.SAMPLE_W(W), .CLK_DIV(DIV), .HALF_W(HW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .half_period_i(hp),
    .frame_inv_i(finv), .bclk_inv_i(binv), .s_valid_i(s_valid),
    .s_ready_o(s_ready), .s_left_i(s_left), .s_right_i(s_right),
    .bclk_o(bclk), .lrclk_o(lrclk), .sdata_o(sdata), .underrun_o(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  logic cap_lr[0:255], cap_sd[0:255], cap_un[0:255];
  int   cap_cyc[0:255];
  int   ncap, target, ready_cnt, idx, nvalid;
  logic prev_raw, took;
  logic [W-1:0] lw[0:3], rw[0:3];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      ncap = 0; prev_raw = 1'b1; idx = 0; took = 1'b0; ready_cnt = 0;
      s_valid = 1'b0;
    end else begin
      logic raw;
      raw = bclk ^ binv;
      if (!prev_raw && raw && ncap < 256) begin
        cap_lr[ncap] = lrclk; cap_sd[ncap] = sdata; cap_un[ncap] = underrun;
        cap_cyc[ncap] = cyc; ncap++;
      end
      prev_raw = raw;
      if (ncap < target && s_ready) ready_cnt++;
      if (took) idx++;
      s_valid = (idx < nvalid);
      s_left  = (idx < 4) ? lw[idx] : '0;
      s_right = (idx < 4) ? rw[idx] : '0;
      took = s_ready && s_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nslots();
    return int'(hp) + 1;
  endfunction

  // bit of frame f at slot k before the format offset is applied
  function automatic logic pay(input int f, input int k);
    int n; logic [W-1:0] l, r;
    n = nslots();
    l = (f < nvalid) ? lw[f] : '0;
    r = (f < nvalid) ? rw[f] : '0;
    case (fmt)
      3'd2: begin
        int j, lead; logic [W-1:0] b;
        j = k % n; lead = n - W; b = (k < n) ? l : r;
        return (j >= lead) ? b[W-1-(j-lead)] : 1'b0;
      end
      3'd3, 3'd4: begin
        if (k < W) return l[W-1-k];
        if (k < 2*W) return r[2*W-1-k];
        return 1'b0;
      end
      default: begin
        if (k < n) return (k < W) ? l[W-1-k] : 1'b0;
        return (k-n < W) ? r[W-1-(k-n)] : 1'b0;
      end
    endcase
  endfunction

  function automatic logic exp_sd(input int g);
    int off, h;
    off = (fmt == 3'd1 || fmt == 3'd2 || fmt == 3'd4) ? 0 : 1;
    if (g < off) return 1'b0;
    h = g - off;
    return pay(h / (2*nslots()), h % (2*nslots()));
  endfunction

  function automatic logic exp_lr(input int g);
    logic st; int k;
    st = ((fmt == 3'd0) ? 1'b0 : 1'b1) ^ finv;
    k = g % (2*nslots());
    if (fmt == 3'd3 || fmt == 3'd4) return (k == 0) ? st : ~st;
    return (k < nslots()) ? st : ~st;
  endfunction

  task automatic start_case(input logic [2:0] f, input int h, input logic fi, input logic bi,
                            input int nv, input int frames);
    @(negedge clk);
    rst_n = 1'b0;
    fmt = f; hp = HW'(h); finv = fi; binv = bi; nvalid = nv;
    target = frames * 2 * (h + 1);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    for (int i = 0; i < 20000 && ncap < target; i++) @(negedge clk);
    chk(ncap >= target, "R2", "capture timeout slots", ncap, target);
  endtask

  task automatic check_stream(input string req_lr, input string req_sd, input int frames);
    int bad_lr = 0, bad_sd = 0, bad_un = 0, fb = -1, fa = 0, fe = 0;
    for (int g = 0; g < target; g++) begin
      if (cap_lr[g] !== exp_lr(g)) bad_lr++;
      if (cap_sd[g] !== exp_sd(g)) begin
        bad_sd++;
        if (fb < 0) begin fb = g; fa = cap_sd[g]; fe = exp_sd(g); end
      end
      if (cap_un[g] !== ((g / (2*nslots())) >= nvalid)) bad_un++;
    end
    chk(bad_lr == 0, req_lr, "lrclk slot mismatches", bad_lr, 0);
    chk(bad_sd == 0, req_sd, $sformatf("sdata mismatches (first slot %0d: %0d vs %0d)", fb, fa, fe), bad_sd, 0);
    chk(bad_un == 0, "R11", "underrun slot mismatches", bad_un, 0);
    chk(ready_cnt == frames, "R10", "ready pulse cycles", ready_cnt, frames);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; binv = 1'b0;
    repeat (2) @(negedge clk);
    chk(bclk == 1'b1, "R1", "bclk idle level in reset", bclk, 1);
    chk(sdata == 1'b0, "R1", "sdata in reset", sdata, 0);
    chk(s_ready == 1'b0, "R10", "ready in reset", s_ready, 0);
    chk(underrun == 1'b0, "R11", "underrun in reset", underrun, 0);
    binv = 1'b1; #1;
    chk(bclk == 1'b0, "R9", "inverted bclk idle level", bclk, 0);
    binv = 1'b0;
  endtask

  task automatic t_i2s();
    start_case(3'd0, 19, 1'b0, 1'b0, 4, 3);
    check_stream("R3", "R3", 3);
    chk(cap_cyc[1] - cap_cyc[0] == 2*DIV, "R1", "bclk period cycles", cap_cyc[1] - cap_cyc[0], 2*DIV);
  endtask

  task automatic t_i2s_spill();
    start_case(3'd0, 15, 1'b0, 1'b0, 4, 3);
    check_stream("R2", "R12", 3);
    chk(cap_sd[32] == rw[0][0], "R12", "right LSB in next frame slot 0", cap_sd[32], rw[0][0]);
  endtask

  task automatic t_i2s_finv();
    start_case(3'd0, 19, 1'b1, 1'b0, 4, 2);
    check_stream("R8", "R8", 2);
    chk(cap_lr[0] == 1'b1, "R8", "inverted I2S start level", cap_lr[0], 1);
  endtask

  task automatic t_lj_binv();
    start_case(3'd1, 19, 1'b0, 1'b1, 4, 3);
    check_stream("R4", "R9", 3);
    chk(cap_sd[0] == lw[0][W-1], "R4", "left MSB in slot 0", cap_sd[0], lw[0][W-1]);
  endtask

  task automatic t_rj_finv();
    start_case(3'd2, 19, 1'b1, 1'b0, 4, 3);
    check_stream("R8", "R5", 3);
    chk(cap_lr[0] == 1'b0, "R8", "inverted RJ start level", cap_lr[0], 0);
  endtask

  task automatic t_dspa();
    start_case(3'd3, 17, 1'b0, 1'b0, 4, 3);
    check_stream("R6", "R6", 3);
  endtask

  task automatic t_dspb_underrun();
    start_case(3'd4, 17, 1'b0, 1'b0, 1, 3);
    check_stream("R7", "R7", 3);
    chk(cap_un[36] == 1'b1, "R11", "underrun in second frame", cap_un[36], 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    lw[0] = 16'hA5C3; lw[1] = 16'h1234; lw[2] = 16'hF00F; lw[3] = 16'h8001;
    rw[0] = 16'h5A3D; rw[1] = 16'hCAFE; rw[2] = 16'h0FF1; rw[3] = 16'h7FFE;
    nvalid = 0; target = 0;
    t_reset();
    t_i2s();
    t_i2s_spill();
    t_i2s_finv();
    t_lj_binv();
    t_rj_finv();
    t_dspa();
    t_dspb_underrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule